// File: doc/BRIEF.md
# Dual-Port Parallel I/O Control Decoder

This block is a two-port, byte-wide parallel I/O peripheral. A host writes and reads it over a simple register bus with a two-bit offset. Each port has two registers: a data register and a control register. Bytes written to a control register pass through a small per-port sequencer. The sequencer sorts each byte into one of three kinds, using the low nibble and whether a follow-on byte is expected: a mode command, an interrupt command, or a direction or mask byte.

The mode of a port sets how its eight pins behave. The port can drive them all, sample them all, or drive them while also sampling them. In bit mode each pin is an input or an output on its own, as set by the direction byte. In bit mode the port also raises a level-sensitive interrupt request. The request compares the unmasked input pins against a programmable active level and combines them with OR or AND.

Pin-side signals are split into a sampled input, a driven value and an output enable per port, so the surrounding pad logic forms the tristate.

Top module: `pio_dual_port`

## Requirements
- R1: Bus offset 0 is the port A data register, 1 the port B data register, 2 the port A control register and 3 the port B control register; reads at offsets 2 and 3 return 0x00.
- R2: After reset both ports are in byte input mode (all output enables low), the data registers are 0x00, interrupts are disabled, AND matching and active-high matching are off, the mask is 0x00, the direction byte is 0xFF (all inputs) and no follow-on byte is pending.
- R3: A control byte with low nibble 0xF, written while no follow-on byte is pending, is a mode command; bits [7:6] select byte input (0), byte output (1), bidirectional (2) or bit mode (3). The output enables are 0x00 in byte input mode, 0xFF in byte output and bidirectional modes, and the inverse of the direction byte in bit mode.
- R4: After a mode command selecting bit mode, the next control byte to that port is stored as the direction byte (bit set = input), and the byte after it is decoded as a command again.
- R5: A control byte with low nibble 0x7, written while no follow-on byte is pending, is an interrupt command: bit 7 enables the request, bit 6 selects AND matching (0 = OR), bit 5 selects active-high (0 = active-low).
- R6: If bit 4 of an interrupt command is set, the next control byte to that port is stored as the mask (bit set = pin excluded from matching), and the byte after it is decoded as a command again.
- R7: A control byte whose low nibble is neither 0xF nor 0x7, written while no follow-on byte is pending, changes nothing.
- R8: A data read returns the pins sampled in that cycle in byte input and bidirectional modes, the data register in byte output mode, and in bit mode pin values for input pins and data register bits for output pins. Driven pin values always equal the data register.
- R9: A data write replaces the whole data register in byte modes; in bit mode it changes only bits of output pins.
- R10: In bit mode with the request enabled and OR matching, the request is high exactly when at least one unmasked input pin is at the active level.
- R11: In bit mode with the request enabled and AND matching, the request is high exactly when there is at least one unmasked input pin and all unmasked input pins are at the active level.
- R12: The request is low whenever the port is not in bit mode or the request is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| pa_in | input | 8 | Sampled pin values, port A |
| pa_out | output | 8 | Driven pin values, port A |
| pa_oe | output | 8 | Per-pin output enable, port A |
| pa_irq | output | 1 | Interrupt request, port A |
| pb_in | input | 8 | Sampled pin values, port B |
| pb_out | output | 8 | Driven pin values, port B |
| pb_oe | output | 8 | Per-pin output enable, port B |
| pb_irq | output | 1 | Interrupt request, port B |

## Verification
The bench aims at the follow-on sequencing. A byte such as 0x0F or 0x17 must land in the direction or mask register when it follows a bit-mode or mask-enable command. A design that decoded it as a command would switch mode or reprogram interrupts; one that never cleared the pending flag would swallow every later command. It drives bit-mode data writes against mixed directions, where a design writing the full byte would corrupt the latched input-pin bits seen once those pins turn into outputs. It also covers AND matching with every input masked, where a naive reduction would raise a spurious request, and bytes with neither signature, which must leave the whole configuration as it was.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PW = 8;
  localparam int NPORT = 2;
  localparam logic [3:0] SIG_MODE = 4'hF;
  localparam logic [3:0] SIG_INTR = 4'h7;

  typedef enum logic [1:0] {
    M_IN    = 2'd0,
    M_OUT   = 2'd1,
    M_BIDIR = 2'd2,
    M_BIT   = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    F_NONE = 2'd0,
    F_DIR  = 2'd1,
    F_MASK = 2'd2
  } follow_e;

  typedef struct packed {
    pmode_e        mode;
    logic [PW-1:0] dir;
    logic [PW-1:0] mask;
    logic          ie;
    logic          and_m;
    logic          hi;
  } pcfg_t;
endpackage

// File: rtl/pio_ctrl_fsm.sv
module pio_ctrl_fsm
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [PW-1:0] ctrl_byte,
  output pcfg_t         cfg
);
  pcfg_t   cfg_q, cfg_d;
  follow_e pend_q, pend_d;

  always_comb begin
    cfg_d  = cfg_q;
    pend_d = pend_q;
    if (ctrl_we) begin
      case (pend_q)
        F_DIR: begin
          cfg_d.dir = ctrl_byte;
          pend_d    = F_NONE;
        end
        F_MASK: begin
          cfg_d.mask = ctrl_byte;
          pend_d     = F_NONE;
        end
        default: begin
          if (ctrl_byte[3:0] == SIG_MODE) begin
            cfg_d.mode = pmode_e'(ctrl_byte[7:6]);
            pend_d     = (ctrl_byte[7:6] == 2'd3) ? F_DIR : F_NONE;
          end else if (ctrl_byte[3:0] == SIG_INTR) begin
            cfg_d.ie    = ctrl_byte[7];
            cfg_d.and_m = ctrl_byte[6];
            cfg_d.hi    = ctrl_byte[5];
            pend_d      = ctrl_byte[4] ? F_MASK : F_NONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.mode  <= M_IN;
      cfg_q.dir   <= '1;
      cfg_q.mask  <= '0;
      cfg_q.ie    <= 1'b0;
      cfg_q.and_m <= 1'b0;
      cfg_q.hi    <= 1'b0;
      pend_q      <= F_NONE;
    end else if (ctrl_we) begin
      cfg_q  <= cfg_d;
      pend_q <= pend_d;
    end
  end

  assign cfg = cfg_q;

  // R4 / R6: a pending follow-on byte is consumed by the next control write
  p_followon_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && pend_q != F_NONE) |=> (pend_q == F_NONE));

  // R7: a byte with no signature and nothing pending leaves the setup alone
  p_unknown_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && pend_q == F_NONE && ctrl_byte[3:0] != SIG_MODE &&
     ctrl_byte[3:0] != SIG_INTR) |=> ($stable(cfg_q) && pend_q == F_NONE));
endmodule

// File: rtl/pio_port_io.sv
module pio_port_io
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic [PW-1:0] wdata,
  input  pcfg_t         cfg,
  input  logic [PW-1:0] pins_in,
  output logic [PW-1:0] data_rd,
  output logic [PW-1:0] pins_out,
  output logic [PW-1:0] pins_oe
);
  logic [PW-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (data_we) begin
      if (cfg.mode == M_BIT) data_d = (data_q & cfg.dir) | (wdata & ~cfg.dir);
      else                   data_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_we) data_q <= data_d;
  end

  always_comb begin
    case (cfg.mode)
      M_OUT: begin
        pins_oe = '1;
        data_rd = data_q;
      end
      M_BIDIR: begin
        pins_oe = '1;
        data_rd = pins_in;
      end
      M_BIT: begin
        pins_oe = ~cfg.dir;
        data_rd = (pins_in & cfg.dir) | (data_q & ~cfg.dir);
      end
      default: begin
        pins_oe = '0;
        data_rd = pins_in;
      end
    endcase
  end

  assign pins_out = data_q;

  // R9: bit-mode writes never touch the latched bits of input pins
  p_bitwrite_keeps_inputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && cfg.mode == M_BIT) |=>
      ((data_q & $past(cfg.dir)) == ($past(data_q) & $past(cfg.dir))));

  // R3: byte input mode drives no pin
  p_input_mode_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == M_IN) |-> (pins_oe == '0));
endmodule

// File: rtl/pio_irq_eval.sv
module pio_irq_eval
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  pcfg_t         cfg,
  input  logic [PW-1:0] pins_in,
  output logic          irq
);
  logic [PW-1:0] watched, at_level, hit;
  logic          any_hit, all_hit;

  always_comb begin
    watched  = cfg.dir & ~cfg.mask;
    at_level = cfg.hi ? pins_in : ~pins_in;
    hit      = watched & at_level;
    any_hit  = |hit;
    all_hit  = (watched != '0) && (hit == watched);
    irq      = cfg.ie && (cfg.mode == M_BIT) && (cfg.and_m ? all_hit : any_hit);
  end

  // R12: no request outside enabled bit mode
  p_irq_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg.ie && cfg.mode == M_BIT));

  // R11: in AND matching a request implies some pin is being watched
  p_and_needs_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && cfg.and_m) |-> ((cfg.dir & ~cfg.mask) != '0));
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  output logic       pa_irq,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  output logic       pb_irq
);
  logic [PW-1:0] pin_in [NPORT];
  logic [PW-1:0] pin_out[NPORT];
  logic [PW-1:0] pin_oe [NPORT];
  logic [PW-1:0] rd     [NPORT];
  logic          irq    [NPORT];

  assign pin_in[0] = pa_in;
  assign pin_in[1] = pb_in;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pcfg_t cfg;
    logic  ctrl_we, data_we;

    assign data_we = bus_wr && (bus_addr == {1'b0, 1'(p)});
    assign ctrl_we = bus_wr && (bus_addr == {1'b1, 1'(p)});

    pio_ctrl_fsm u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_byte(bus_wdata), .cfg(cfg)
    );
    pio_port_io u_io (
      .clk(clk), .rst_n(rst_n), .data_we(data_we), .wdata(bus_wdata), .cfg(cfg),
      .pins_in(pin_in[p]), .data_rd(rd[p]), .pins_out(pin_out[p]), .pins_oe(pin_oe[p])
    );
    pio_irq_eval u_irq (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .pins_in(pin_in[p]), .irq(irq[p])
    );
  end

  assign bus_rdata = bus_addr[1] ? '0 : rd[bus_addr[0]];

  assign pa_out = pin_out[0];
  assign pa_oe  = pin_oe[0];
  assign pa_irq = irq[0];
  assign pb_out = pin_out[1];
  assign pb_oe  = pin_oe[1];
  assign pb_irq = irq[1];

  // R1: control offsets read back as zero
  p_ctrl_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[1] |-> (bus_rdata == 8'h00));
endmodule

// File: tb/tb_pio_dual_port.sv
module tb_pio_dual_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
  logic       pa_irq, pb_irq;

  int errors = 0;
  int checks = 0;

  // reference model, per port
  logic [1:0] m_mode [2];
  logic [7:0] m_dir  [2];
  logic [7:0] m_mask [2];
  logic [7:0] m_data [2];
  logic       m_ie   [2];
  logic       m_and  [2];
  logic       m_hi   [2];
  int         m_pend [2];   // 0 none, 1 direction, 2 mask

  always #4 clk = ~clk;   // 125 MHz

  pio_dual_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_irq(pa_irq),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_irq(pb_irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pins_of(input int p);
    return (p == 0) ? pa_in : pb_in;
  endfunction

  function automatic logic [7:0] exp_oe(input int p);
    case (m_mode[p])
      2'd1, 2'd2: return 8'hFF;
      2'd3:       return ~m_dir[p];
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input int p);
    case (m_mode[p])
      2'd1:    return m_data[p];
      2'd3:    return (pins_of(p) & m_dir[p]) | (m_data[p] & ~m_dir[p]);
      default: return pins_of(p);
    endcase
  endfunction

  function automatic logic exp_irq(input int p);
    logic [7:0] w, lv, h;
    if (!(m_ie[p] && m_mode[p] == 2'd3)) return 1'b0;
    w  = m_dir[p] & ~m_mask[p];
    lv = m_hi[p] ? pins_of(p) : ~pins_of(p);
    h  = w & lv;
    if (m_and[p]) return (w != 0) && (h == w);
    return h != 0;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      m_mode[p] = 2'd0; m_dir[p] = 8'hFF; m_mask[p] = 8'h00; m_data[p] = 8'h00;
      m_ie[p] = 1'b0; m_and[p] = 1'b0; m_hi[p] = 1'b0; m_pend[p] = 0;
    end
  endtask

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    int p;
    p = a[0];
    if (!a[1]) begin
      if (m_mode[p] == 2'd3) m_data[p] = (m_data[p] & m_dir[p]) | (d & ~m_dir[p]);
      else                   m_data[p] = d;
    end else if (m_pend[p] == 1) begin
      m_dir[p] = d; m_pend[p] = 0;
    end else if (m_pend[p] == 2) begin
      m_mask[p] = d; m_pend[p] = 0;
    end else if (d[3:0] == 4'hF) begin
      m_mode[p] = d[7:6];
      m_pend[p] = (d[7:6] == 2'd3) ? 1 : 0;
    end else if (d[3:0] == 4'h7) begin
      m_ie[p] = d[7]; m_and[p] = d[6]; m_hi[p] = d[5];
      m_pend[p] = d[4] ? 2 : 0;
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic set_pins(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    pa_in = a; pb_in = b;
  endtask

  task automatic check_all(input string tag);
    for (int p = 0; p < 2; p++) begin
      #1;
      chk((tag == "") ? "R3" : tag, "oe", (p == 0) ? pa_oe : pb_oe, exp_oe(p));
      chk((tag == "") ? "R8" : tag, "pins_out", (p == 0) ? pa_out : pb_out, m_data[p]);
      chk((tag == "") ? (m_ie[p] && m_mode[p] == 2'd3 ? (m_and[p] ? "R11" : "R10") : "R12") : tag,
          "irq", (p == 0) ? pa_irq : pb_irq, exp_irq(p));
    end
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      #1;
      if (a >= 2) chk((tag == "") ? "R1" : tag, "ctrl read", bus_rdata, 0);
      else        chk((tag == "") ? "R8" : tag, "data read", bus_rdata, exp_rd(a));
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    pa_in = 8'h3C; pb_in = 8'hC3;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    check_all("R2");

    // R3 byte output on A, R9 full write, R1 offset map
    bus_write(2'd2, 8'h4F);
    bus_write(2'd0, 8'hA5);
    check_all("R3");
    // R3 bidirectional on B
    bus_write(2'd3, 8'h8F);
    bus_write(2'd1, 8'h5A);
    check_all("R8");

    // R4 bit mode, then 0x0F must be taken as direction, not a mode command
    bus_write(2'd2, 8'hCF);
    bus_write(2'd2, 8'h0F);
    check_all("R4");
    // R9 bit-mode write touches output bits only
    bus_write(2'd0, 8'hFF);
    check_all("R9");
    // turn every pin into an output to expose the latched data
    bus_write(2'd2, 8'hCF);
    bus_write(2'd2, 8'h00);
    check_all("R9");
    bus_write(2'd2, 8'hCF);
    bus_write(2'd2, 8'hF0);

    // R7 unknown byte ignored
    bus_write(2'd2, 8'h55);
    check_all("R7");

    // R6 mask follow-on: 0x17 after enable must become the mask
    bus_write(2'd2, 8'hB7);   // enable, OR, active-high, mask follows
    bus_write(2'd2, 8'h17);
    check_all("R6");
    set_pins(8'h10, pb_in);   // masked pin active -> no request
    check_all("R10");
    set_pins(8'h20, pb_in);   // unmasked pin active
    check_all("R10");

    // R11 AND with every input masked: no request
    bus_write(2'd2, 8'hF7);
    bus_write(2'd2, 8'hFF);
    set_pins(8'hFF, pb_in);
    check_all("R11");
    bus_write(2'd2, 8'hD7);   // AND, active-low, mask follows
    bus_write(2'd2, 8'h0F);
    set_pins(8'h00, pb_in);
    check_all("R11");
    set_pins(8'h40, pb_in);
    check_all("R11");

    // R12 leave bit mode with interrupts still enabled
    bus_write(2'd2, 8'h0F);
    check_all("R12");
    // R5 disable request in bit mode
    bus_write(2'd2, 8'hCF);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd2, 8'h07);
    check_all("R5");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] b;
      op = $urandom % 8;
      b  = 8'($urandom);
      case (op)
        0, 1, 2: begin
          case ($urandom % 4)
            0: b[3:0] = 4'hF;
            1: b[3:0] = 4'h7;
            default: ;
          endcase
          bus_write({1'b1, 1'($urandom % 2)}, b);
        end
        3, 4: bus_write({1'b0, 1'($urandom % 2)}, b);
        default: set_pins(8'($urandom), 8'($urandom));
      endcase
      check_all("");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule